// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block passes an 18-bit word between two ports, A and B, with one independent path for each direction. The A-to-B path and the B-to-A path each have a storage stage. A mode input selects whether the stage is a transparent latch or an edge-capture register. The capture edge comes from a per-direction strobe, which is sampled on the system clock. Each path ends in an output driver with its own enable. The A-to-B enable is active high and the B-to-A enable is active low.

The pins are tri-state, but the block models them as a data-out vector plus a drive-enable bit, so it stays synthesizable. Every input pin also carries a per-bit "driven" flag. When that flag is low, a bus-keeper register supplies the last value that was driven on that bit. The storage stage therefore never sees a floating input, and no pull resistors are needed.

Top module: `bxcv_top`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals the effective A input in the same cycle. A rising `ab_strb` does not interrupt this, and a change of `a_in` made after that edge still appears on `b_out` at once.
- R2: While `ab_le` is 0 and `ab_strb` stays low, stays high or falls, the stored A-to-B word does not change, whatever `a_in` does.
- R3: A rising strobe is `ab_strb` sampled at 1 on a `clk` edge after it was sampled at 0 on the edge before. While `ab_le` is 0, a rising strobe stores the effective A input at that `clk` edge. The stored word appears on `b_out` just after that edge and not before it.
- R4: `ab_en` is active high. When it is 1, `b_oe` is 1 and `b_out` carries the path data. When it is 0, `b_oe` is 0 and `b_out` is all zeros. Storage still updates while the output is disabled.
- R5: The B-to-A path follows R1 to R3 with `ba_le`, `ba_strb` and `b_in`, and its data appears on `a_out`.
- R6: `ba_en_n` is active low. When it is 0, `a_oe` is 1 and `a_out` carries the path data. When it is 1, `a_oe` is 0 and `a_out` is all zeros.
- R7: For each bit, the effective input is the pin value when its driven flag (`a_vld`/`b_vld`) is 1, and the keeper value otherwise. The keeper for a bit loads the pin on each `clk` edge where that bit's flag is 1, and keeps its value otherwise.
- R8: A synchronous `rst` clears both stored words, both keepers and both strobe histories. Because the history is cleared, a strobe that is high on the first edge after reset counts as a rising strobe.
- R9: With both outputs enabled, `b_out` depends only on A-side data and `a_out` depends only on B-side data. A port whose output is enabled must have every driven flag at 0. Any other case is contention, and the checker reports it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | A pin value seen as input |
| a_vld | input | 18 | Per-bit driven flag for A pins |
| b_in | input | 18 | B pin value seen as input |
| b_vld | input | 18 | Per-bit driven flag for B pins |
| ab_le | input | 1 | A-to-B latch mode: 1 transparent, 0 hold/capture |
| ab_strb | input | 1 | A-to-B capture strobe (rising edge) |
| ab_en | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch mode: 1 transparent, 0 hold/capture |
| ba_strb | input | 1 | B-to-A capture strobe (rising edge) |
| ba_en_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data driven onto B pins |
| b_oe | output | 1 | Drive enable for B pins |
| a_out | output | 18 | Data driven onto A pins |
| a_oe | output | 1 | Drive enable for A pins |

## Verification
The assertions take for granted that no port is driven from outside while its own output is enabled. In other words, every driven flag of a port is 0 whenever that port's drive enable is 1. The capture and hold properties also assume that the strobes change only between `clk` edges and are held for at least one edge. The directed stimulus disables the opposite path, or clears the driven flags, before it enables an output. When both paths are enabled together, both ports are undriven and the keepers supply the data.

// File: rtl/bxcv_pkg.sv
package bxcv_pkg;

   localparam int unsigned BXCV_WIDTH = 18;

   typedef enum logic {
      EN_ACT_HIGH = 1'b0,
      EN_ACT_LOW  = 1'b1
   } en_pol_e;

   typedef enum logic [1:0] {
      ST_PASS = 2'd0,
      ST_HOLD = 2'd1,
      ST_CAPT = 2'd2
   } stage_mode_e;

   function automatic stage_mode_e pick_mode(input logic le, input logic rise);
      if (le)
         return ST_PASS;
      else if (rise)
         return ST_CAPT;
      else
         return ST_HOLD;
   endfunction

endpackage

// File: rtl/bxcv_hold.sv
module bxcv_hold #(
   parameter int unsigned W    = 18,
   parameter bit          KEEP = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pin,
   input  logic [W-1:0] drv,
   output logic [W-1:0] eff
);

   if (W < 1) begin : g_bad_w
      $error("bxcv_hold: W must be at least 1");
   end

   if (KEEP) begin : g_keep
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic kept_q;
         always_ff @(posedge clk) begin
            if (rst)
               kept_q <= 1'b0;
            else if (drv[i])
               kept_q <= pin[i];
         end
         assign eff[i] = drv[i] ? pin[i] : kept_q;
      end
   end else begin : g_nokeep
      logic unused_ok;
      assign unused_ok = clk ^ rst ^ (^drv);
      assign eff       = pin;
   end

endmodule

// File: rtl/bxcv_stage.sv
module bxcv_stage
   import bxcv_pkg::*;
#(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         le,
   input  logic         strb,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (W < 1) begin : g_bad_w
      $error("bxcv_stage: W must be at least 1");
   end

   logic        strb_q;
   logic        rise;
   logic [W-1:0] mem_q;
   stage_mode_e mode;

   assign rise = strb & ~strb_q;
   assign mode = pick_mode(le, rise);

   always_ff @(posedge clk) begin
      if (rst) begin
         strb_q <= 1'b0;
         mem_q  <= '0;
      end else begin
         strb_q <= strb;
         if (mode != ST_HOLD)
            mem_q <= din;
      end
   end

   assign dout = (mode == ST_PASS) ? din : mem_q;

endmodule

// File: rtl/bxcv_drive.sv
module bxcv_drive
   import bxcv_pkg::*;
#(
   parameter int unsigned W   = 18,
   parameter en_pol_e     POL = EN_ACT_HIGH
) (
   input  logic         en_pin,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         oe
);

   if (W < 1) begin : g_bad_w
      $error("bxcv_drive: W must be at least 1");
   end

   if (POL == EN_ACT_LOW) begin : g_low
      assign oe = ~en_pin;
   end else begin : g_high
      assign oe = en_pin;
   end

   assign dout = oe ? din : '0;

endmodule

// File: rtl/bxcv_lane.sv
module bxcv_lane
   import bxcv_pkg::*;
#(
   parameter int unsigned W    = 18,
   parameter en_pol_e     POL  = EN_ACT_HIGH,
   parameter bit          KEEP = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pin,
   input  logic [W-1:0] drv,
   input  logic         le,
   input  logic         strb,
   input  logic         en_pin,
   output logic [W-1:0] dout,
   output logic         oe
);

   logic [W-1:0] eff;
   logic [W-1:0] staged;

   bxcv_hold #(.W(W), .KEEP(KEEP)) u_hold (
      .clk (clk),
      .rst (rst),
      .pin (pin),
      .drv (drv),
      .eff (eff)
   );

   bxcv_stage #(.W(W)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .le   (le),
      .strb (strb),
      .din  (eff),
      .dout (staged)
   );

   bxcv_drive #(.W(W), .POL(POL)) u_drive (
      .en_pin (en_pin),
      .din    (staged),
      .dout   (dout),
      .oe     (oe)
   );

endmodule

// File: rtl/bxcv_top.sv
module bxcv_top
   import bxcv_pkg::*;
#(
   parameter int unsigned W      = BXCV_WIDTH,
   parameter bit          KEEP_A = 1'b1,
   parameter bit          KEEP_B = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] a_vld,
   input  logic [W-1:0] b_in,
   input  logic [W-1:0] b_vld,
   input  logic         ab_le,
   input  logic         ab_strb,
   input  logic         ab_en,
   input  logic         ba_le,
   input  logic         ba_strb,
   input  logic         ba_en_n,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   output logic [W-1:0] a_out,
   output logic         a_oe
);

   localparam int unsigned NDIR = 2;

   if (W < 1) begin : g_bad_w
      $error("bxcv_top: W must be at least 1");
   end

   logic [NDIR-1:0][W-1:0] src_pin;
   logic [NDIR-1:0][W-1:0] src_drv;
   logic [NDIR-1:0][W-1:0] dst_dat;
   logic [NDIR-1:0]        le_v;
   logic [NDIR-1:0]        strb_v;
   logic [NDIR-1:0]        en_v;
   logic [NDIR-1:0]        oe_v;

   // index 0 carries A to B, index 1 carries B to A
   assign src_pin[0] = a_in;
   assign src_pin[1] = b_in;
   assign src_drv[0] = a_vld;
   assign src_drv[1] = b_vld;
   assign le_v       = {ba_le, ab_le};
   assign strb_v     = {ba_strb, ab_strb};
   assign en_v       = {ba_en_n, ab_en};

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      localparam en_pol_e P = (d == 0) ? EN_ACT_HIGH : EN_ACT_LOW;
      localparam bit      K = (d == 0) ? KEEP_A : KEEP_B;
      bxcv_lane #(.W(W), .POL(P), .KEEP(K)) u_lane (
         .clk    (clk),
         .rst    (rst),
         .pin    (src_pin[d]),
         .drv    (src_drv[d]),
         .le     (le_v[d]),
         .strb   (strb_v[d]),
         .en_pin (en_v[d]),
         .dout   (dst_dat[d]),
         .oe     (oe_v[d])
      );
   end

   assign b_out = dst_dat[0];
   assign b_oe  = oe_v[0];
   assign a_out = dst_dat[1];
   assign a_oe  = oe_v[1];

endmodule

// File: rtl/bxcv_top_chk.sv
module bxcv_top_chk #(
   parameter int unsigned W = 18
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_vld,
   input logic [W-1:0] b_in,
   input logic [W-1:0] b_vld,
   input logic         ab_le,
   input logic         ab_strb,
   input logic         ab_en,
   input logic         ba_le,
   input logic         ba_strb,
   input logic         ba_en_n,
   input logic [W-1:0] b_out,
   input logic         b_oe,
   input logic [W-1:0] a_out,
   input logic         a_oe
);

   AST_AB_PASS: assert property (@(posedge clk) disable iff (rst)
      (ab_le && (&a_vld) && ab_en) |-> (b_out == a_in)); // R1

   AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!rst, 2) && !ab_le && $past(!ab_le) && ab_en && $past(ab_en)
       && !($past(ab_strb) && !$past(ab_strb, 2))) |-> $stable(b_out)); // R2

   AST_AB_CAPT: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!rst, 2) && $past(ab_strb) && !$past(ab_strb, 2)
       && $past(!ab_le) && $past(&a_vld) && !ab_le && ab_en) |-> (b_out == $past(a_in))); // R3

   AST_AB_OFF: assert property (@(posedge clk) disable iff (rst)
      !ab_en |-> (!b_oe && b_out == '0)); // R4

   AST_BA_PASS: assert property (@(posedge clk) disable iff (rst)
      (ba_le && (&b_vld) && !ba_en_n) |-> (a_out == b_in)); // R5

   AST_BA_OFF: assert property (@(posedge clk) disable iff (rst)
      ba_en_n |-> (!a_oe && a_out == '0)); // R6

   AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && ab_le && $past(ab_le) && ab_en && $past(ab_en)
       && a_vld == '0 && $past(a_vld == '0)) |-> $stable(b_out)); // R7

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !ab_le && ab_en) |-> (b_out == '0)); // R8

   AST_NO_CONTENTION_A: assert property (@(posedge clk) disable iff (rst)
      a_oe |-> (a_vld == '0)); // R9

   AST_NO_CONTENTION_B: assert property (@(posedge clk) disable iff (rst)
      b_oe |-> (b_vld == '0)); // R9

endmodule

bind bxcv_top bxcv_top_chk #(.W(W)) u_chk (.*);

// File: tb/bxcv_top_tb_top.sv
module bxcv_top_tb_top;

   localparam int W = 18;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] a_in, a_vld, b_in, b_vld;
   logic         ab_le, ab_strb, ab_en, ba_le, ba_strb, ba_en_n;
   logic [W-1:0] b_out, a_out;
   logic         b_oe, a_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   bxcv_top dut_i (
      .clk(clk), .rst(rst),
      .a_in(a_in), .a_vld(a_vld), .b_in(b_in), .b_vld(b_vld),
      .ab_le(ab_le), .ab_strb(ab_strb), .ab_en(ab_en),
      .ba_le(ba_le), .ba_strb(ba_strb), .ba_en_n(ba_en_n),
      .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      // R8: outputs zero after reset with both paths enabled in hold mode
      ab_en = 1'b1; ba_en_n = 1'b0;
      #1;
      chk("R8 b_out after reset", b_out, '0);
      chk("R8 a_out after reset", a_out, '0);
      chk("R4 b_oe enabled", {17'd0, b_oe}, 18'd1);
      chk("R6 a_oe enabled", {17'd0, a_oe}, 18'd1);
      ba_en_n = 1'b1;
   endtask

   task automatic t_ab_pass();
      a_vld = ONES; ab_le = 1'b1; a_in = 18'h2A5C3;
      #1; chk("R1 transparent", b_out, 18'h2A5C3);
      ab_strb = 1'b1; tick();
      a_in = 18'h1B0F4;
      #1; chk("R1 follows after strobe edge", b_out, 18'h1B0F4);
      tick(); chk("R1 still follows", b_out, 18'h1B0F4);
      ab_strb = 1'b0; tick();
   endtask

   task automatic t_ab_hold();
      ab_le = 1'b1; a_in = 18'h0C0DE; tick();
      ab_le = 1'b0; a_in = 18'h3FF00;
      #1; chk("R2 hold on le fall", b_out, 18'h0C0DE);
      tick(); tick(); tick();
      chk("R2 hold strobe low", b_out, 18'h0C0DE);
   endtask

   task automatic t_ab_capt();
      a_in = 18'h12345; ab_strb = 1'b1;
      #1; chk("R3 not before edge", b_out, 18'h0C0DE);
      tick(); chk("R3 captured", b_out, 18'h12345);
      a_in = 18'h25A5A; tick(); tick(); tick();
      chk("R2 hold strobe high", b_out, 18'h12345);
      ab_strb = 1'b0; tick();
      chk("R2 hold on falling strobe", b_out, 18'h12345);
   endtask

   task automatic t_ab_oe();
      ab_en = 1'b0;
      #1; chk("R4 b_oe off", {17'd0, b_oe}, '0);
      chk("R4 b_out zero", b_out, '0);
      a_in = 18'h0BEEF; ab_strb = 1'b1; tick();
      ab_strb = 1'b0; tick();
      ab_en = 1'b1;
      #1; chk("R4 stored while disabled", b_out, 18'h0BEEF);
   endtask

   task automatic t_ba();
      ab_en = 1'b0; a_vld = '0; b_vld = ONES; ba_en_n = 1'b0;
      ba_le = 1'b1; b_in = 18'h31337;
      #1; chk("R5 transparent", a_out, 18'h31337);
      chk("R6 a_oe on", {17'd0, a_oe}, 18'd1);
      tick();
      ba_le = 1'b0; b_in = 18'h05555; tick();
      chk("R5 hold", a_out, 18'h31337);
      ba_strb = 1'b1; tick();
      chk("R5 capture", a_out, 18'h05555);
      ba_en_n = 1'b1;
      #1; chk("R6 a_oe off", {17'd0, a_oe}, '0);
      chk("R6 a_out zero", a_out, '0);
      ba_strb = 1'b0; b_vld = '0; tick();
   endtask

   task automatic t_keep();
      logic [W-1:0] m;
      m = 18'h001FF;
      ab_en = 1'b1; ba_en_n = 1'b1; ab_le = 1'b1;
      a_vld = ONES; a_in = 18'h2C3A1; tick();
      a_vld = '0; a_in = ~18'h2C3A1;
      #1; chk("R7 keeper supplies value", b_out, 18'h2C3A1);
      tick(); tick();
      chk("R7 keeper unchanged while undriven", b_out, 18'h2C3A1);
      a_vld = m; a_in = 18'h1E0F7;
      #1; chk("R7 per-bit mix", b_out, (18'h1E0F7 & m) | (18'h2C3A1 & ~m));
      tick(); a_vld = '0; a_in = '0;
      #1; chk("R7 driven bits reloaded", b_out, (18'h1E0F7 & m) | (18'h2C3A1 & ~m));
   endtask

   task automatic t_indep();
      ab_en = 1'b0; ba_en_n = 1'b1;
      a_vld = ONES; a_in = 18'h0AAAA; b_vld = ONES; b_in = 18'h35555; tick();
      a_vld = '0; b_vld = '0; a_in = 18'h3FFFF; b_in = 18'h00001;
      ab_le = 1'b1; ba_le = 1'b1; ab_en = 1'b1; ba_en_n = 1'b0;
      #1; chk("R9 b_out from A side only", b_out, 18'h0AAAA);
      chk("R9 a_out from B side only", a_out, 18'h35555);
      tick();
      chk("R9 b_out steady", b_out, 18'h0AAAA);
      chk("R9 a_out steady", a_out, 18'h35555);
   endtask

   task automatic t_midreset();
      ab_le = 1'b0; ba_le = 1'b0; ab_strb = 1'b1; ba_strb = 1'b0;
      rst = 1'b1; tick(); tick(); rst = 1'b0;
      #1; chk("R8 b_out cleared", b_out, '0);
      chk("R8 a_out cleared", a_out, '0);
      ab_le = 1'b1; ba_le = 1'b1;
      #1; chk("R8 A keeper cleared", b_out, '0);
      chk("R8 B keeper cleared", a_out, '0);
      ab_le = 1'b0; ba_le = 1'b0; ba_en_n = 1'b1;
      a_vld = ONES; a_in = 18'h2468A; tick();
      chk("R8 strobe high after reset counts as rise", b_out, 18'h2468A);
   endtask

   initial begin
      rst = 1'b1;
      a_in = '0; a_vld = '0; b_in = '0; b_vld = '0;
      ab_le = 1'b0; ab_strb = 1'b0; ab_en = 1'b0;
      ba_le = 1'b0; ba_strb = 1'b0; ba_en_n = 1'b1;
      tick(); tick();
      rst = 1'b0;
      tick();
      t_reset();
      t_ab_pass();
      t_ab_hold();
      t_ab_capt();
      t_ab_oe();
      t_ba();
      t_keep();
      t_indep();
      t_midreset();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule